// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns one PWM command into the two gate enables of a half-bridge: one for the high-side switch and one for the low-side switch. It has no fixed dead time. Before a switch may turn on, the block waits until comparator feedback shows that the opposite switch has really turned off. It then adds a short delay, counted in clock cycles. This keeps both switches from conducting at the same time, and keeps the gap between them as short as the hardware allows.

When PWM rises, the low gate is dropped first. The low-gate comparator is then masked for a blanking window. After the window, the block waits for the low-gate-below-threshold flag and then counts a turn-on delay before it raises the high gate. When PWM falls, the high gate is dropped first. The low gate is then released by whichever of two flags is seen first: the phase node going low, which uses a short delay, or the high-gate-to-phase voltage collapsing, which uses a longer delay. A low power-good flag or a shutdown request overrides everything and holds both gates off. All comparator flags are assumed to be synchronous to the clock already. Control pins are plain levels, with no handshake.

Top module: `gate_seq_top`

## Requirements
- R1: While `pwr_ok` is sampled low, the next cycle shows `state_o`=0 with `hi_en` and `lo_en` both low. `pwm` has no effect on either gate in this condition.
- R2: While `pwr_ok` is high and `shdn` is sampled high, the next cycle shows `state_o`=1 with both gates low.
- R3: If `pwm` is sampled high while the low gate is on (`state_o`=2), `lo_en` is low in the next cycle and `state_o`=3 (blanking). Blanking lasts exactly BLANK_CYC cycles.
- R4: During blanking, `lg_low` is ignored. After blanking, the block waits in `state_o`=4 until `lg_low` is sampled high.
- R5: After `lg_low` is accepted, `state_o`=5 lasts exactly HI_DLY_CYC cycles. Then `hi_en` rises and `state_o`=6.
- R6: If `pwm` is sampled low while the high gate is on, `hi_en` is low in the next cycle. The block then waits in `state_o`=7 until a release flag is sampled.
- R7: If `ph_low` is sampled high in `state_o`=7, the release delay (`state_o`=8) lasts PH_DLY_CYC cycles. Then `lo_en` rises and `state_o`=2. If `ph_low` and `hgp_low` are high in the same cycle, this phase path is used.
- R8: If only `hgp_low` is sampled high in `state_o`=7, the release delay lasts HGP_DLY_CYC cycles. The chosen path stays locked: flags seen during the delay do not shorten it.
- R9: A change of `pwm` during blanking, the low-gate wait or either turn-on delay cancels the pending turn-on. A low `pwm` goes to `state_o`=7. A high `pwm` goes to `state_o`=3 with a fresh blanking window.
- R10: `hi_en` and `lo_en` are never high in the same cycle.
- R11: Leaving the power-down or shutdown state (`state_o`=0 or 1), a high `pwm` enters blanking (`state_o`=3) and a low `pwm` enters the release wait (`state_o`=7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply above its power-on level |
| pwm | input | 1 | Decoded PWM level |
| shdn | input | 1 | Shutdown request, forces both gates off |
| lg_low | input | 1 | Low-gate voltage below threshold |
| ph_low | input | 1 | Phase node below threshold |
| hgp_low | input | 1 | High-gate-to-phase voltage below threshold |
| hi_en | output | 1 | High-side gate enable |
| lo_en | output | 1 | Low-side gate enable |
| state_o | output | 4 | Sequencer state code |

## Verification
The bench builds the block with BLANK_CYC=3, HI_DLY_CYC=2, PH_DLY_CYC=1 and HGP_DLY_CYC=4. These short windows make it easy to reverse PWM inside each pending delay. A release delay of one cycle exercises the shortest possible count. The long and short release paths are far enough apart that a path lock can be seen when the phase flag arrives late during the long delay. Directed cases cover blanking with the low-gate flag already high, simultaneous release flags and power loss during conduction. A long pseudo-random stretch then mixes all inputs.

// File: rtl/gs_pkg.sv
package gs_pkg;

  typedef enum logic [3:0] {
    ST_PREPOR   = 4'd0,
    ST_SHDN     = 4'd1,
    ST_LO_ON    = 4'd2,
    ST_BLANK    = 4'd3,
    ST_LG_WAIT  = 4'd4,
    ST_HI_DLY   = 4'd5,
    ST_HI_ON    = 4'd6,
    ST_REL_WAIT = 4'd7,
    ST_LO_DLY   = 4'd8
  } gs_state_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/gs_timer.sv
module gs_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/gs_release_arb.sv
module gs_release_arb #(
  parameter int CW          = 4,
  parameter int PH_DLY_CYC  = 2,
  parameter int HGP_DLY_CYC = 8
) (
  input  logic          ph_low,
  input  logic          hgp_low,
  output logic          fire,
  output logic [CW-1:0] dly_val
);
  localparam logic [CW-1:0] PH_V  = CW'(PH_DLY_CYC - 1);
  localparam logic [CW-1:0] HGP_V = CW'(HGP_DLY_CYC - 1);

  assign fire = ph_low | hgp_low;

  // The phase path is the faster one and wins a tie.
  always_comb begin
    if (ph_low) dly_val = PH_V;
    else        dly_val = HGP_V;
  end
endmodule

// File: rtl/gs_fsm.sv
module gs_fsm
  import gs_pkg::*;
#(
  parameter int CW         = 4,
  parameter int BLANK_CYC  = 5,
  parameter int HI_DLY_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok,
  input  logic          shdn,
  input  logic          pwm,
  input  logic          lg_low,
  input  logic          rel_fire,
  input  logic [CW-1:0] rel_dly,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          hi_req,
  output logic          lo_req,
  output gs_state_e     state
);
  localparam logic [CW-1:0] BLANK_V = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] HI_V    = CW'(HI_DLY_CYC - 1);

  gs_state_e nxt;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (!pwr_ok) begin
      nxt = ST_PREPOR;
    end else if (shdn) begin
      nxt = ST_SHDN;
    end else begin
      unique case (state)
        ST_PREPOR, ST_SHDN, ST_LO_ON: begin
          if (pwm) begin
            nxt = ST_BLANK; tmr_load = 1'b1; tmr_val = BLANK_V;
          end else if (state != ST_LO_ON) begin
            nxt = ST_REL_WAIT;
          end
        end
        ST_BLANK: begin
          if (!pwm)          nxt = ST_REL_WAIT;
          else if (tmr_zero) nxt = ST_LG_WAIT;
        end
        ST_LG_WAIT: begin
          if (!pwm) begin
            nxt = ST_REL_WAIT;
          end else if (lg_low) begin
            nxt = ST_HI_DLY; tmr_load = 1'b1; tmr_val = HI_V;
          end
        end
        ST_HI_DLY: begin
          if (!pwm)          nxt = ST_REL_WAIT;
          else if (tmr_zero) nxt = ST_HI_ON;
        end
        ST_HI_ON: begin
          if (!pwm) nxt = ST_REL_WAIT;
        end
        ST_REL_WAIT: begin
          if (pwm) begin
            nxt = ST_BLANK; tmr_load = 1'b1; tmr_val = BLANK_V;
          end else if (rel_fire) begin
            nxt = ST_LO_DLY; tmr_load = 1'b1; tmr_val = rel_dly;
          end
        end
        ST_LO_DLY: begin
          if (pwm) begin
            nxt = ST_BLANK; tmr_load = 1'b1; tmr_val = BLANK_V;
          end else if (tmr_zero) begin
            nxt = ST_LO_ON;
          end
        end
        default: nxt = ST_PREPOR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_PREPOR;
    else        state <= nxt;
  end

  assign hi_req = (nxt == ST_HI_ON);
  assign lo_req = (nxt == ST_LO_ON);
endmodule

// File: rtl/gs_gate_out.sv
module gs_gate_out (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic shdn,
  input  logic hi_req,
  input  logic lo_req,
  output logic hi_en,
  output logic lo_en
);
  logic allow;
  assign allow = pwr_ok & ~shdn;

  // Second guard: a request is dropped if both ask at once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_en <= 1'b0;
      lo_en <= 1'b0;
    end else begin
      hi_en <= allow & hi_req & ~lo_req;
      lo_en <= allow & lo_req & ~hi_req;
    end
  end
endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top
  import gs_pkg::*;
#(
  parameter int BLANK_CYC   = 5,
  parameter int HI_DLY_CYC  = 4,
  parameter int PH_DLY_CYC  = 2,
  parameter int HGP_DLY_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       pwm,
  input  logic       shdn,
  input  logic       lg_low,
  input  logic       ph_low,
  input  logic       hgp_low,
  output logic       hi_en,
  output logic       lo_en,
  output logic [3:0] state_o
);
  localparam int MAXD = max4(BLANK_CYC, HI_DLY_CYC, PH_DLY_CYC, HGP_DLY_CYC);
  localparam int CW   = (MAXD < 2) ? 1 : $clog2(MAXD);

  logic          tmr_load, tmr_zero, rel_fire, hi_req, lo_req;
  logic [CW-1:0] tmr_val, rel_dly;
  gs_state_e     st;

  gs_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  gs_release_arb #(.CW(CW), .PH_DLY_CYC(PH_DLY_CYC), .HGP_DLY_CYC(HGP_DLY_CYC)) u_arb (
    .ph_low(ph_low), .hgp_low(hgp_low), .fire(rel_fire), .dly_val(rel_dly)
  );

  gs_fsm #(.CW(CW), .BLANK_CYC(BLANK_CYC), .HI_DLY_CYC(HI_DLY_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .shdn(shdn), .pwm(pwm),
    .lg_low(lg_low), .rel_fire(rel_fire), .rel_dly(rel_dly), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .hi_req(hi_req), .lo_req(lo_req),
    .state(st)
  );

  gs_gate_out u_out (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .shdn(shdn),
    .hi_req(hi_req), .lo_req(lo_req), .hi_en(hi_en), .lo_en(lo_en)
  );

  assign state_o = 4'(st);
endmodule

// File: rtl/gs_checker.sv
module gs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_ok,
  input logic       pwm,
  input logic       shdn,
  input logic       hi_en,
  input logic       lo_en,
  input logic [3:0] state_o
);
  p_never_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_en && lo_en));

  p_prepor_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (state_o == 4'd0 && !hi_en && !lo_en));

  p_shdn_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && shdn) |=> (state_o == 4'd1 && !hi_en && !lo_en));

  p_rise_drops_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_en && pwm && pwr_ok && !shdn) |=> (!lo_en && state_o == 4'd3));

  p_blank_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd3 && pwm && pwr_ok && !shdn) |=> (state_o == 4'd3 || state_o == 4'd4));

  p_hi_after_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_en) |-> ($past(state_o) == 4'd5));

  p_fall_drops_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en && !pwm && pwr_ok && !shdn) |=> (!hi_en && state_o == 4'd7));

  p_lo_after_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_en) |-> ($past(state_o) == 4'd8));
endmodule

bind gate_seq_top gs_checker u_gs_checker (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .pwm(pwm), .shdn(shdn),
  .hi_en(hi_en), .lo_en(lo_en), .state_o(state_o)
);

// File: tb/test_gate_seq_top.sv
module test_gate_seq_top;
  localparam int BL = 3, HD = 2, PD = 1, GD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_ok = 1'b0, pwm = 1'b0, shdn = 1'b0;
  logic lg_low = 1'b0, ph_low = 1'b0, hgp_low = 1'b0;
  logic hi_en, lo_en;
  logic [3:0] state_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  gate_seq_top #(.BLANK_CYC(BL), .HI_DLY_CYC(HD), .PH_DLY_CYC(PD), .HGP_DLY_CYC(GD))
    i_gate_seq_top (
      .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .pwm(pwm), .shdn(shdn),
      .lg_low(lg_low), .ph_low(ph_low), .hgp_low(hgp_low),
      .hi_en(hi_en), .lo_en(lo_en), .state_o(state_o));

  always #4 clk = ~clk;

  // Reference model: phase number, cycles left in a timed phase, requirement tag.
  int    m_ph   = 0;
  int    m_left = 0;
  string m_tag  = "R1";

  task automatic m_enter_blank(input string tag);
    m_ph = 3; m_left = BL; m_tag = tag;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_tag = "R1";
    end else if (!pwr_ok) begin
      m_ph = 0; m_tag = "R1";
    end else if (shdn) begin
      m_ph = 1; m_tag = "R2";
    end else begin
      case (m_ph)
        0, 1: if (pwm) m_enter_blank("R11"); else begin m_ph = 7; m_tag = "R11"; end
        2: if (pwm) m_enter_blank("R3");
        3: if (!pwm) begin m_ph = 7; m_tag = "R9"; end
           else begin m_left--; if (m_left == 0) begin m_ph = 4; m_tag = "R4"; end end
        4: if (!pwm) begin m_ph = 7; m_tag = "R9"; end
           else if (lg_low) begin m_ph = 5; m_left = HD; m_tag = "R5"; end
        5: if (!pwm) begin m_ph = 7; m_tag = "R9"; end
           else begin m_left--; if (m_left == 0) begin m_ph = 6; m_tag = "R5"; end end
        6: if (!pwm) begin m_ph = 7; m_tag = "R6"; end
        7: if (pwm) m_enter_blank("R9");
           else if (ph_low) begin m_ph = 8; m_left = PD; m_tag = "R7"; end
           else if (hgp_low) begin m_ph = 8; m_left = GD; m_tag = "R8"; end
        8: if (pwm) m_enter_blank("R9");
           else begin m_left--; if (m_left == 0) m_ph = 2; end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (state_o != 4'(m_ph)) begin
        n_bad++;
        $display("FAIL %s state actual=%0d expected=%0d t=%0t", m_tag, state_o, m_ph, $time);
      end
      n_cmp++;
      if (hi_en != (m_ph == 6)) begin
        n_bad++;
        $display("FAIL %s hi_en actual=%0b expected=%0b t=%0t", m_tag, hi_en, m_ph == 6, $time);
      end
      n_cmp++;
      if (lo_en != (m_ph == 2)) begin
        n_bad++;
        $display("FAIL %s lo_en actual=%0b expected=%0b t=%0t", m_tag, lo_en, m_ph == 2, $time);
      end
      n_cmp++;
      if (hi_en && lo_en) begin   // R10 overlap
        n_bad++;
        $display("FAIL R10 overlap actual=11 expected=not both t=%0t", $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drv(input logic p, input logic lg, input logic ph, input logic hg);
    @(negedge clk);
    pwm = p; lg_low = lg; ph_low = ph; hgp_low = hg;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    pwm = 1'b1; cyc(3);                         // R1: pwm ignored while power is low
    @(negedge clk); pwr_ok = 1'b1; pwm = 1'b0;  // R11: low pwm -> release wait
    cyc(2);
    drv(0, 0, 1, 0); drv(0, 0, 0, 0); cyc(3);   // R7: phase path, 1 cycle
    drv(1, 1, 0, 0); cyc(6);                    // R3/R4: lg_low high during blank ignored
    drv(0, 0, 0, 0); cyc(2);                    // R6
    drv(0, 0, 0, 1); drv(0, 0, 1, 0);           // R8: long path locked, late phase flag
    drv(0, 0, 0, 0); cyc(5);
    drv(1, 0, 0, 0); cyc(6);                    // R4: wait for lg_low
    drv(1, 1, 0, 0); drv(1, 0, 0, 0);
    drv(0, 0, 0, 0);                            // R9: cancel in HI_DLY
    drv(0, 0, 1, 1); drv(0, 0, 0, 0);           // R7: tie chooses phase path
    cyc(3);
    drv(1, 0, 0, 0); drv(0, 0, 0, 0); cyc(2);   // R9: cancel in blanking
    drv(0, 0, 0, 1); drv(1, 0, 0, 0); cyc(2);   // R9: cancel in LO_DLY
    drv(1, 1, 0, 0); cyc(8);                    // R5: high gate on
    @(negedge clk); shdn = 1'b1; cyc(3);        // R2
    @(negedge clk); shdn = 1'b0; cyc(8);        // R11: high pwm -> blank
    @(negedge clk); pwr_ok = 1'b0; cyc(3);      // R1: power loss while on
    @(negedge clk); pwr_ok = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      pwm     = ($urandom % 8) < 4 ? pwm : ~pwm;
      lg_low  = ($urandom % 3) == 0;
      ph_low  = ($urandom % 5) == 0;
      hgp_low = ($urandom % 4) == 0;
      shdn    = ($urandom % 97) == 0;
      pwr_ok  = ($urandom % 211) != 0;
    end
    cyc(2);
    done = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end
endmodule